// File: doc/BRIEF.md
# Serial-Loaded Bank Mapping Controller

This block watches processor writes to the upper half of a 16-bit address space and turns them into bank selections for an external cartridge memory system. Software loads one bit per write: data bit 0 of five successive writes is gathered, least significant bit first, into a 5-bit value. On the fifth write that value goes into one of four internal registers. Address bits 14:13 of that fifth write pick the register. Any such write with data bit 7 set drops a partial load and returns the control register to its power-up value.

The four registers are a control register, two character-bank registers and a program-bank register. From them the block drives two 16 KB program-window bank numbers, two 4 KB character-window bank numbers and one page-select bit for each of the four nametable quadrants. All bank numbers are reduced modulo a bank count given as a parameter, so small memories wrap. The outputs are combinational from the registers and change right after the clock edge that accepts the write.

Top module: `bank_map_ctrl`

## Requirements
- R1: After reset the control register holds 0x0C, the other registers hold 0 and the load count is 0. The outputs are then: lower program bank 0, upper program bank PRG_BANKS-1, character banks 0 and 1, and page 0 for every quadrant.
- R2: A write with cpuWe high, cpuAddr[15] = 1 and cpuData[7] = 1 clears the load count and the partial value, and sets the control register to 0x0C. The next load then starts again at bit 0.
- R3: A write with cpuAddr[15] = 1 and cpuData[7] = 0 places cpuData[0] at the bit given by the load count, so the first write is bit 0. On the fifth such write the value is stored into the register chosen by that write's cpuAddr[14:13]: 0 is control, 1 is character A, 2 is character B, 3 is program. The count then returns to 0.
- R4: Writes with cpuAddr[15] = 0, and cycles with cpuWe low, change neither the load state nor any output.
- R5: ntPage[q] is the page for quadrant q. Control bits 1:0 give the pattern: 0 sets all quadrants to page 0, 1 sets all to page 1, 2 gives ntPage = 4'b1010, and 3 gives ntPage = 4'b1100.
- R6: With control bit 4 set, chrBank0 is the character A register and chrBank1 is the character B register.
- R7: With control bit 4 clear, chrBank0 is character A with bit 0 cleared, and chrBank1 is that value plus one.
- R8: With control bits 3:2 at 0 or 1, prgBankLo is 2 times program bits 3:1 and prgBankHi is that value plus one. Together they select one 32 KB bank.
- R9: With control bits 3:2 at 2, prgBankLo is 0 and prgBankHi is program bits 3:0.
- R10: With control bits 3:2 at 3, prgBankLo is program bits 3:0 and prgBankHi is PRG_BANKS-1.
- R11: Each program bank output is taken modulo PRG_BANKS, and each character bank output modulo CHR_BANKS.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cpuAddr | input | 16 | Processor address |
| cpuData | input | 8 | Processor write data |
| cpuWe | input | 1 | Write strobe, one cycle per write |
| prgBankLo | output | PRG_W | 16 KB bank number for the lower program window |
| prgBankHi | output | PRG_W | 16 KB bank number for the upper program window |
| chrBank0 | output | CHR_W | 4 KB bank number for the first character window |
| chrBank1 | output | CHR_W | 4 KB bank number for the second character window |
| ntPage | output | 4 | Page select for each nametable quadrant, bit q for quadrant q |

## Verification
The loads use asymmetric values such as 0x03 against 0x18, which tells LSB-first assembly apart from MSB-first. Issuing the first four writes at one address and the fifth at another shows that only the fifth write picks the register. Each control mode is tried for each output group, and bank values past the bank count show the wrap. A reset write in the middle of a load, together with stray writes below 0x8000 and with the strobe low between bits, separates a real abort from an ignored write.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;
  localparam int REG_W = 5;
  localparam int CNT_W = 3;
  localparam logic [REG_W-1:0] CTRL_RESET = 5'h0C;

  typedef struct packed {
    logic             forceCtrl;
    logic             shiftIn;
    logic             commit;
    logic [1:0]       target;
    logic [CNT_W-1:0] bitPos;
    logic             dataBit;
  } shift_strobe_t;
endpackage

// File: rtl/shift_ctrl.sv
module shift_ctrl
  import bank_map_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [15:0]      cpuAddr,
  input  logic [7:0]       cpuData,
  input  logic             cpuWe,
  output shift_strobe_t    strobe,
  output logic [CNT_W-1:0] shiftCnt
);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(REG_W - 1);

  logic upperHit;

  always_comb begin
    upperHit = cpuWe & cpuAddr[15];
    strobe = '0;
    strobe.bitPos  = shiftCnt;
    strobe.dataBit = cpuData[0];
    strobe.target  = cpuAddr[14:13];
    if (upperHit) begin
      if (cpuData[7]) strobe.forceCtrl = 1'b1;
      else if (shiftCnt == LAST_POS) strobe.commit = 1'b1;
      else strobe.shiftIn = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftCnt <= '0;
    else if (strobe.forceCtrl || strobe.commit) shiftCnt <= '0;
    else if (strobe.shiftIn) shiftCnt <= shiftCnt + 1'b1;
  end
endmodule

// File: rtl/bank_regs.sv
module bank_regs
  import bank_map_pkg::*;
#(
  parameter int PRG_BANKS = 8,
  parameter int CHR_BANKS = 16,
  localparam int PRG_W = (PRG_BANKS > 1) ? $clog2(PRG_BANKS) : 1,
  localparam int CHR_W = (CHR_BANKS > 1) ? $clog2(CHR_BANKS) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  shift_strobe_t strobe,
  output logic [PRG_W-1:0] prgBankLo,
  output logic [PRG_W-1:0] prgBankHi,
  output logic [CHR_W-1:0] chrBank0,
  output logic [CHR_W-1:0] chrBank1,
  output logic [3:0]       ntPage
);
  localparam logic [REG_W-1:0] PRG_LAST = REG_W'(PRG_BANKS - 1);

  logic [REG_W-1:0] regFile [4];
  logic [REG_W-2:0] accBits;
  logic [REG_W-1:0] ctrlReg, chrA, chrB, prgReg;
  logic [REG_W-1:0] prgLoRaw, prgHiRaw, chr0Raw, chr1Raw;

  assign ctrlReg = regFile[0];
  assign chrA    = regFile[1];
  assign chrB    = regFile[2];
  assign prgReg  = regFile[3];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regFile[0] <= CTRL_RESET;
      regFile[1] <= '0;
      regFile[2] <= '0;
      regFile[3] <= '0;
      accBits    <= '0;
    end else if (strobe.forceCtrl) begin
      regFile[0] <= CTRL_RESET;
      accBits    <= '0;
    end else if (strobe.commit) begin
      regFile[strobe.target] <= {strobe.dataBit, accBits};
      accBits <= '0;
    end else if (strobe.shiftIn) begin
      accBits[strobe.bitPos[1:0]] <= strobe.dataBit;
    end
  end

  always_comb begin
    case (ctrlReg[3:2])
      2'd2: begin
        prgLoRaw = '0;
        prgHiRaw = {1'b0, prgReg[3:0]};
      end
      2'd3: begin
        prgLoRaw = {1'b0, prgReg[3:0]};
        prgHiRaw = PRG_LAST;
      end
      default: begin
        prgLoRaw = {1'b0, prgReg[3:1], 1'b0};
        prgHiRaw = {1'b0, prgReg[3:1], 1'b1};
      end
    endcase
    if (ctrlReg[4]) begin
      chr0Raw = chrA;
      chr1Raw = chrB;
    end else begin
      chr0Raw = {chrA[4:1], 1'b0};
      chr1Raw = {chrA[4:1], 1'b1};
    end
  end

  assign prgBankLo = PRG_W'(int'(prgLoRaw) % PRG_BANKS);
  assign prgBankHi = PRG_W'(int'(prgHiRaw) % PRG_BANKS);
  assign chrBank0  = CHR_W'(int'(chr0Raw) % CHR_BANKS);
  assign chrBank1  = CHR_W'(int'(chr1Raw) % CHR_BANKS);

  for (genvar q = 0; q < 4; q++) begin : g_quad
    localparam logic [1:0] QIDX = 2'(q);
    always_comb begin
      case (ctrlReg[1:0])
        2'd0: ntPage[q] = 1'b0;
        2'd1: ntPage[q] = 1'b1;
        2'd2: ntPage[q] = QIDX[0];
        default: ntPage[q] = QIDX[1];
      endcase
    end
  end
endmodule

// File: rtl/bank_map_ctrl.sv
module bank_map_ctrl
  import bank_map_pkg::*;
#(
  parameter int PRG_BANKS = 8,
  parameter int CHR_BANKS = 16,
  localparam int PRG_W = (PRG_BANKS > 1) ? $clog2(PRG_BANKS) : 1,
  localparam int CHR_W = (CHR_BANKS > 1) ? $clog2(CHR_BANKS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [15:0]      cpuAddr,
  input  logic [7:0]       cpuData,
  input  logic             cpuWe,
  output logic [PRG_W-1:0] prgBankLo,
  output logic [PRG_W-1:0] prgBankHi,
  output logic [CHR_W-1:0] chrBank0,
  output logic [CHR_W-1:0] chrBank1,
  output logic [3:0]       ntPage
);
  shift_strobe_t    strobe;
  logic [CNT_W-1:0] shiftCnt;

  shift_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuData(cpuData),
    .cpuWe(cpuWe), .strobe(strobe), .shiftCnt(shiftCnt)
  );

  bank_regs #(.PRG_BANKS(PRG_BANKS), .CHR_BANKS(CHR_BANKS)) u_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .prgBankLo(prgBankLo), .prgBankHi(prgBankHi),
    .chrBank0(chrBank0), .chrBank1(chrBank1), .ntPage(ntPage)
  );
endmodule

// File: rtl/bank_map_chk.sv
module bank_map_chk #(
  parameter int PRG_BANKS = 8,
  parameter int CHR_BANKS = 16,
  localparam int PRG_W = (PRG_BANKS > 1) ? $clog2(PRG_BANKS) : 1,
  localparam int CHR_W = (CHR_BANKS > 1) ? $clog2(CHR_BANKS) : 1
) (
  input logic             clk,
  input logic             rstN,
  input logic [15:0]      cpuAddr,
  input logic [7:0]       cpuData,
  input logic             cpuWe,
  input logic [PRG_W-1:0] prgBankLo,
  input logic [PRG_W-1:0] prgBankHi,
  input logic [CHR_W-1:0] chrBank0,
  input logic [CHR_W-1:0] chrBank1,
  input logic [3:0]       ntPage,
  input logic [2:0]       shiftCnt
);
  // R4
  low_write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cpuWe || !cpuAddr[15]) |=> ($stable(shiftCnt) && $stable(prgBankLo) &&
      $stable(prgBankHi) && $stable(chrBank0) && $stable(chrBank1) && $stable(ntPage)));

  // R2
  abort_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWe && cpuAddr[15] && cpuData[7]) |=>
      (shiftCnt == 3'd0 && ntPage == 4'b0000 && prgBankHi == PRG_W'(PRG_BANKS - 1)));

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWe && cpuAddr[15] && !cpuData[7] && shiftCnt < 3'd4) |=>
      (shiftCnt == $past(shiftCnt) + 3'd1));

  // R3
  fifth_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWe && cpuAddr[15] && !cpuData[7] && shiftCnt == 3'd4) |=> (shiftCnt == 3'd0));

  always @(negedge clk) begin
    if (rstN) begin
      // R5
      nt_pattern_chk: assert (ntPage == 4'b0000 || ntPage == 4'b1111 ||
                              ntPage == 4'b1010 || ntPage == 4'b1100);
      // R11
      bank_range_chk: assert (int'(prgBankLo) < PRG_BANKS && int'(prgBankHi) < PRG_BANKS &&
                              int'(chrBank0) < CHR_BANKS && int'(chrBank1) < CHR_BANKS);
    end
  end
endmodule

bind bank_map_ctrl bank_map_chk #(.PRG_BANKS(PRG_BANKS), .CHR_BANKS(CHR_BANKS)) u_chk (
  .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuData(cpuData), .cpuWe(cpuWe),
  .prgBankLo(prgBankLo), .prgBankHi(prgBankHi), .chrBank0(chrBank0),
  .chrBank1(chrBank1), .ntPage(ntPage), .shiftCnt(shiftCnt)
);

// File: tb/test_bank_map_ctrl.sv
module test_bank_map_ctrl;
  localparam int PRG_BANKS = 8;
  localparam int CHR_BANKS = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [7:0]  cpuData = '0;
  logic        cpuWe = 1'b0;
  logic [2:0]  prgBankLo, prgBankHi;
  logic [3:0]  chrBank0, chrBank1;
  logic [3:0]  ntPage;

  int nVec = 0;
  int nBad = 0;
  int shCtrl = 'h0C, shChrA = 0, shChrB = 0, shPrg = 0;

  always #10 clk = ~clk;

  bank_map_ctrl #(.PRG_BANKS(PRG_BANKS), .CHR_BANKS(CHR_BANKS)) i_bank_map_ctrl (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuData(cpuData), .cpuWe(cpuWe),
    .prgBankLo(prgBankLo), .prgBankHi(prgBankHi), .chrBank0(chrBank0),
    .chrBank1(chrBank1), .ntPage(ntPage)
  );

  task automatic busWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpuAddr = a; cpuData = d; cpuWe = 1'b1;
    @(negedge clk);
    cpuWe = 1'b0; cpuAddr = '0; cpuData = 8'h00;
  endtask

  task automatic loadReg(input logic [15:0] a, input int v);
    for (int i = 0; i < 5; i++) busWrite(a, 8'((v >> i) & 1));
    case ((a >> 13) & 3)
      0: shCtrl = v; 1: shChrA = v; 2: shChrB = v; default: shPrg = v;
    endcase
  endtask

  task automatic checkAll(input string tag);
    int eLo, eHi, e0, e1, eNt;
    case ((shCtrl >> 2) & 3)
      2: begin eLo = 0; eHi = shPrg & 15; end
      3: begin eLo = shPrg & 15; eHi = PRG_BANKS - 1; end
      default: begin eLo = ((shPrg >> 1) & 7) * 2; eHi = eLo + 1; end
    endcase
    if ((shCtrl >> 4) & 1) begin e0 = shChrA; e1 = shChrB; end
    else begin e0 = shChrA & 'h1E; e1 = e0 + 1; end
    case (shCtrl & 3)
      0: eNt = 0; 1: eNt = 'hF; 2: eNt = 'hA; default: eNt = 'hC;
    endcase
    eLo = eLo % PRG_BANKS; eHi = eHi % PRG_BANKS;
    e0 = e0 % CHR_BANKS; e1 = e1 % CHR_BANKS;
    nVec++;
    if (int'(prgBankLo) != eLo || int'(prgBankHi) != eHi || int'(chrBank0) != e0 ||
        int'(chrBank1) != e1 || int'(ntPage) != eNt) begin
      nBad++;
      $display("FAIL %s: got prg %0d/%0d chr %0d/%0d nt %b, expected prg %0d/%0d chr %0d/%0d nt %b",
               tag, prgBankLo, prgBankHi, chrBank0, chrBank1, ntPage, eLo, eHi, e0, e1, 4'(eNt));
    end
  endtask

  task automatic t_reset;
    checkAll("R1 reset state");
  endtask

  task automatic t_nametable;
    for (int m = 0; m < 4; m++) begin
      loadReg(16'h8000, 'h0C | m);
      checkAll("R5 nametable mode");
    end
  endtask

  task automatic t_order;
    loadReg(16'h8000, 'h1C);
    loadReg(16'hA000, 'h03);
    checkAll("R3 lsb first value 3");
    loadReg(16'hA000, 'h18);
    checkAll("R3 lsb first value 0x18");
    for (int i = 0; i < 4; i++) busWrite(16'h8000, 8'(i == 0));
    busWrite(16'hE000, 8'h00);
    shPrg = 1;
    checkAll("R3 fifth write address selects program register");
  endtask

  task automatic t_chr;
    loadReg(16'h8000, 'h1C);
    loadReg(16'hA000, 'h05);
    loadReg(16'hC000, 'h09);
    checkAll("R6 independent character banks");
    loadReg(16'h8000, 'h0C);
    checkAll("R7 paired character banks");
    loadReg(16'hA000, 'h1F);
    checkAll("R7 R11 paired banks wrap");
    loadReg(16'h8000, 'h1C);
    checkAll("R6 R11 independent bank wrap");
  endtask

  task automatic t_prg;
    loadReg(16'hE000, 'h06);
    loadReg(16'h8000, 'h00);
    checkAll("R8 mode 0");
    loadReg(16'h8000, 'h04);
    loadReg(16'hE000, 'h0E);
    checkAll("R8 R11 mode 1 wrap");
    loadReg(16'h8000, 'h08);
    loadReg(16'hE000, 'h0A);
    checkAll("R9 R11 mode 2");
    loadReg(16'h8000, 'h0C);
    loadReg(16'hE000, 'h05);
    checkAll("R10 mode 3");
    loadReg(16'hE000, 'h0F);
    checkAll("R10 R11 mode 3 wrap");
  endtask

  task automatic t_abort;
    loadReg(16'h8000, 'h13);
    checkAll("R2 setup");
    busWrite(16'hA000, 8'h01);
    busWrite(16'hA000, 8'h01);
    busWrite(16'hA000, 8'h01);
    busWrite(16'hC000, 8'h80);
    shCtrl = 'h0C;
    checkAll("R2 reset write restores control");
    loadReg(16'hA000, 'h04);
    checkAll("R2 load restarts at bit 0");
  endtask

  task automatic t_ignore;
    loadReg(16'h8000, 'h1E);
    busWrite(16'hA000, 8'h00);
    busWrite(16'hA000, 8'h01);
    busWrite(16'h7FFF, 8'h81);
    busWrite(16'h0000, 8'h01);
    @(negedge clk);
    cpuAddr = 16'hA000; cpuData = 8'h80;
    @(negedge clk);
    cpuAddr = '0; cpuData = 8'h00;
    checkAll("R4 stray writes leave outputs");
    busWrite(16'hA000, 8'h01);
    busWrite(16'hA000, 8'h00);
    busWrite(16'hA000, 8'h01);
    shChrA = 'h16;
    checkAll("R4 partial load survives stray writes");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_nametable();
    t_order();
    t_chr();
    t_prg();
    t_abort();
    t_ignore();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule